// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block sits passively beside a two-bank single-data-rate SDRAM command bus and samples the control pins on every rising clock edge. It decodes each command from the chip-select and strobe lines. It keeps an open or closed state for each bank and measures, in clocks, the time since the last activate and the last close of every bank and since the last mode-register load. Any command that breaks a protocol rule or a minimum-interval rule raises an error flag. The flag stays set until reset. A code says which rule broke first.

The minimum intervals are parameters in clocks. Their defaults match a 7.5 ns clock: activate to access 3, activate to precharge 6, precharge to activate 3, activate to activate on the same bank 9, activate to activate across banks 2, and mode load to next command 2. An interval of d clocks means the second command is sampled d edges after the first. A violation is any d below the minimum. Clock-enable low is treated like deselect, because power-down states are not tracked.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is sampled only when cke=1 and cs_n=0. The command is decoded from {cs_n,ras_n,cas_n,we_n}: 0000 mode load, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0110 burst stop, 0001 refresh, 0111 no-op. When cs_n=1 or cke=0 the bank state and the error outputs do not change.
- R2: An activate opens the bank selected by ba. A precharge with a10=1 closes every bank. bank_active bit i shows bank i one clock after the command.
- R3: A precharge with a10=0 closes only the bank named by ba.
- R4: A read or write with a10=1 to an open bank closes that bank. Its precharge-to-activate timer starts at that command.
- R5: A read or write to an open bank fewer than T_RCD (default 3) clocks after that bank's activate sets code 5.
- R6: A precharge that closes an open bank fewer than T_RAS (default 6) clocks after its activate sets code 6.
- R7: An activate to a closed bank fewer than T_RP (default 3) clocks after that bank was closed sets code 7.
- R8: An activate to a closed bank fewer than T_RC (default 9) clocks after that bank's previous activate sets code 8.
- R9: An activate fewer than T_RRD (default 2) clocks after an activate to a different bank sets code 9.
- R10: Any command other than no-op fewer than T_MRD (default 2) clocks after a mode load sets code 1.
- R11: Some commands do not fit the bank state. An activate to an open bank sets code 2. A read or write to a closed bank sets code 3. A refresh or mode load while any bank is open sets code 4.
- R12: err_flag rises one clock after the first violation and holds until reset. err_code keeps the code of that first violation. Reset clears err_flag, err_code and bank_active to 0.
- R13: When several rules break in one command, the lowest code is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (1) | Bank address |
| a10 | input | 1 | All-bank / auto-close flag |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of first violation |
| bank_active | output | NUM_BANKS (2) | Open state per bank |

## Verification
Several rules can break in the same command, and the recorded code then depends on priority. One case is an activate to a bank that is still open and also too early after its last activate. Another is an activate after an auto-closing read, where the gap decides between the precharge-to-activate rule, the activate-to-activate rule, or no violation. The bench sweeps the gap clock by clock for each rule. For every gap it predicts the code from the interval arithmetic and the lowest-code rule. A case that breaks a second rule after the first checks that the first code is kept.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

  typedef enum logic [3:0] {
    OP_IGNORE = 4'd0,
    OP_NOP    = 4'd1,
    OP_MODE   = 4'd2,
    OP_OPEN   = 4'd3,
    OP_READ   = 4'd4,
    OP_WRITE  = 4'd5,
    OP_CLOSE  = 4'd6,
    OP_STOP   = 4'd7,
    OP_REFR   = 4'd8
  } op_t;

  typedef enum logic [3:0] {
    V_NONE    = 4'd0,
    V_MODEGAP = 4'd1,
    V_REOPEN  = 4'd2,
    V_IDLEACC = 4'd3,
    V_BUSYOP  = 4'd4,
    V_RCD     = 4'd5,
    V_RAS     = 4'd6,
    V_RP      = 4'd7,
    V_RC      = 4'd8,
    V_RRD     = 4'd9
  } viol_t;

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
  import sdmon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_t  op
);

  always_comb begin
    if (!cke || cs_n) begin
      op = OP_IGNORE;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  op = OP_MODE;
        3'b011:  op = OP_OPEN;
        3'b101:  op = OP_READ;
        3'b100:  op = OP_WRITE;
        3'b010:  op = OP_CLOSE;
        3'b110:  op = OP_STOP;
        3'b001:  op = OP_REFR;
        default: op = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdmon_age.sv
module sdmon_age #(
  parameter int MAXV = 9,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] age
);

  localparam logic [W-1:0] SAT = W'(MAXV);

  // Saturating count of edges since the last restart; reset reads as "long ago".
  always_ff @(posedge clk) begin
    if (rst)               age <= SAT;
    else if (restart)      age <= W'(1);
    else if (age != SAT)   age <= age + W'(1);
  end

endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
  import sdmon_pkg::*;
#(
  parameter int BA_W  = 1,
  parameter int IDX   = 0,
  parameter int MAXV  = 9,
  localparam int CW   = $clog2(MAXV + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  op_t             op,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            open_q,
  output logic [CW-1:0]   since_open,
  output logic [CW-1:0]   since_close
);

  logic hit;
  logic do_open;
  logic do_close;

  assign hit      = (ba == BA_W'(IDX));
  assign do_open  = (op == OP_OPEN) && hit;
  assign do_close = open_q &&
                    (((op == OP_CLOSE) && (a10 || hit)) ||
                     (((op == OP_READ) || (op == OP_WRITE)) && a10 && hit));

  always_ff @(posedge clk) begin
    if (rst)           open_q <= 1'b0;
    else if (do_open)  open_q <= 1'b1;
    else if (do_close) open_q <= 1'b0;
  end

  sdmon_age #(.MAXV(MAXV)) u_open_age (
    .clk(clk), .rst(rst), .restart(do_open), .age(since_open)
  );

  sdmon_age #(.MAXV(MAXV)) u_close_age (
    .clk(clk), .rst(rst), .restart(do_close), .age(since_close)
  );

endmodule

// File: rtl/sdmon_rules.sv
module sdmon_rules
  import sdmon_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1,
  parameter int CW        = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2
) (
  input  op_t                            op,
  input  logic [BA_W-1:0]                ba,
  input  logic                           a10,
  input  logic [NUM_BANKS-1:0]           open_v,
  input  logic [NUM_BANKS-1:0][CW-1:0]   since_open,
  input  logic [NUM_BANKS-1:0][CW-1:0]   since_close,
  input  logic [CW-1:0]                  since_mode,
  output viol_t                          viol
);

  logic f_modegap, f_reopen, f_idleacc, f_busy;
  logic f_rcd, f_ras, f_rp, f_rc, f_rrd;
  logic is_acc;
  logic sel_open;
  logic [CW-1:0] sel_sopen;
  logic [CW-1:0] sel_sclose;

  assign is_acc     = (op == OP_READ) || (op == OP_WRITE);
  assign sel_open   = open_v[ba];
  assign sel_sopen  = since_open[ba];
  assign sel_sclose = since_close[ba];

  always_comb begin
    f_modegap = (op != OP_IGNORE) && (op != OP_NOP) && (since_mode < CW'(T_MRD));
    f_reopen  = (op == OP_OPEN) && sel_open;
    f_idleacc = is_acc && !sel_open;
    f_busy    = ((op == OP_REFR) || (op == OP_MODE)) && (|open_v);
    f_rcd     = is_acc && sel_open && (sel_sopen < CW'(T_RCD));
    f_rp      = (op == OP_OPEN) && !sel_open && (sel_sclose < CW'(T_RP));
    f_rc      = (op == OP_OPEN) && !sel_open && (sel_sopen < CW'(T_RC));
    f_ras     = 1'b0;
    f_rrd     = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if ((op == OP_CLOSE) && open_v[i] && (a10 || (ba == BA_W'(i))) &&
          (since_open[i] < CW'(T_RAS)))
        f_ras = 1'b1;
      if ((op == OP_OPEN) && (ba != BA_W'(i)) && (since_open[i] < CW'(T_RRD)))
        f_rrd = 1'b1;
    end
  end

  // Lowest code wins.
  always_comb begin
    if      (f_modegap) viol = V_MODEGAP;
    else if (f_reopen)  viol = V_REOPEN;
    else if (f_idleacc) viol = V_IDLEACC;
    else if (f_busy)    viol = V_BUSYOP;
    else if (f_rcd)     viol = V_RCD;
    else if (f_ras)     viol = V_RAS;
    else if (f_rp)      viol = V_RP;
    else if (f_rc)      viol = V_RC;
    else if (f_rrd)     viol = V_RRD;
    else                viol = V_NONE;
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int MAX_T01  = (T_RCD > T_RAS) ? T_RCD : T_RAS,
  localparam int MAX_T23  = (T_RP > T_RC) ? T_RP : T_RC,
  localparam int MAX_T45  = (T_RRD > T_MRD) ? T_RRD : T_MRD,
  localparam int MAX_TA   = (MAX_T01 > MAX_T23) ? MAX_T01 : MAX_T23,
  localparam int MAX_T    = (MAX_TA > MAX_T45) ? MAX_TA : MAX_T45,
  localparam int CW       = $clog2(MAX_T + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic                 err_flag,
  output logic [3:0]           err_code,
  output logic [NUM_BANKS-1:0] bank_active
);

  op_t   op;
  viol_t viol;
  logic [NUM_BANKS-1:0][CW-1:0] since_open;
  logic [NUM_BANKS-1:0][CW-1:0] since_close;
  logic [CW-1:0]                since_mode;

  sdmon_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdmon_bank #(.BA_W(BA_W), .IDX(g), .MAXV(MAX_T)) u_bank (
      .clk(clk), .rst(rst), .op(op), .ba(ba), .a10(a10),
      .open_q(bank_active[g]),
      .since_open(since_open[g]),
      .since_close(since_close[g])
    );
  end

  sdmon_age #(.MAXV(MAX_T)) u_mode_age (
    .clk(clk), .rst(rst), .restart(op == OP_MODE), .age(since_mode)
  );

  sdmon_rules #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .CW(CW),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_RRD(T_RRD), .T_MRD(T_MRD)
  ) u_rules (
    .op(op), .ba(ba), .a10(a10), .open_v(bank_active),
    .since_open(since_open), .since_close(since_close),
    .since_mode(since_mode), .viol(viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_code <= 4'd0;
    end else if (!err_flag && (viol != V_NONE)) begin
      err_flag <= 1'b1;
      err_code <= viol;
    end
  end

endmodule

// File: rtl/sdmon_checker.sv
module sdmon_checker #(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1,
  parameter int T_MRD     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic                 a10,
  input logic                 err_flag,
  input logic [3:0]           err_code,
  input logic [NUM_BANKS-1:0] bank_active
);

  logic vld, c_pre, c_act, c_acc, c_mode, c_nop;
  assign vld    = cke && !cs_n;
  assign c_pre  = vld && ({ras_n, cas_n, we_n} == 3'b010);
  assign c_act  = vld && ({ras_n, cas_n, we_n} == 3'b011);
  assign c_acc  = vld && ((({ras_n, cas_n, we_n}) == 3'b101) || (({ras_n, cas_n, we_n}) == 3'b100));
  assign c_mode = vld && ({ras_n, cas_n, we_n} == 3'b000);
  assign c_nop  = vld && ({ras_n, cas_n, we_n} == 3'b111);

  p_deselect_r1: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(bank_active));

  p_open_r2: assert property (@(posedge clk) disable iff (rst)
    c_act |=> bank_active[$past(ba)]);

  p_close_all_r2: assert property (@(posedge clk) disable iff (rst)
    (c_pre && a10) |=> (bank_active == '0));

  p_close_one_r3: assert property (@(posedge clk) disable iff (rst)
    (c_pre && !a10) |=> !bank_active[$past(ba)]);

  p_autoclose_r4: assert property (@(posedge clk) disable iff (rst)
    (c_acc && a10) |=> !bank_active[$past(ba)]);

  p_modegap_r10: assert property (@(posedge clk) disable iff (rst)
    ((T_MRD >= 2) && vld && !c_nop && $past(c_mode) && $past(!rst) && !err_flag)
      |=> (err_flag && (err_code == 4'd1)));

  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> (err_flag && $stable(err_code)));

  p_flag_code_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> (err_code != 4'd0));

endmodule

bind sdram_cmd_monitor sdmon_checker #(
  .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .T_MRD(T_MRD)
) u_sdmon_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
  .err_flag(err_flag), .err_code(err_code), .bank_active(bank_active)
);

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;

  localparam logic [3:0] P_MODE = 4'b0000, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001,
                         P_NOP = 4'b0111, P_DES = 4'b1111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [0:0] ba = 1'b0;
  logic a10 = 1'b0;
  logic err_flag;
  logic [3:0] err_code;
  logic [1:0] bank_active;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sdram_cmd_monitor dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .err_flag(err_flag), .err_code(err_code), .bank_active(bank_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one command for one edge; returns at the following falling edge.
  task automatic issue(input logic [3:0] p, input logic b, input logic a);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b;
    a10 = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    a10 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) issue(P_NOP, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_DES;
    cke = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R12: reset state
    chk("R12 reset flag", err_flag, 0);
    chk("R12 reset code", err_code, 0);
    chk("R12 reset banks", bank_active, 0);

    // R1: deselect and clock-enable low are ignored
    cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
    chk("R1 deselected act banks", bank_active, 0);
    cke = 1'b0; cs_n = 1'b0; @(negedge clk); cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    chk("R1 cke-low act banks", bank_active, 0);
    chk("R1 no error", err_flag, 0);

    // R5: activate to access, sweep gap
    for (int g = 1; g <= 8; g++) begin
      do_reset();
      issue(P_ACT, 1'b1, 1'b0);
      idle(g - 1);
      issue((g % 2) ? P_RD : P_WR, 1'b1, 1'b0);
      chk($sformatf("R5 gap %0d", g), err_code, (g < 3) ? 5 : 0);
    end

    // R6 and R3: activate to single-bank precharge
    for (int g = 1; g <= 8; g++) begin
      do_reset();
      issue(P_ACT, 1'b0, 1'b0);
      idle(g - 1);
      issue(P_PRE, 1'b0, 1'b0);
      chk($sformatf("R6 gap %0d", g), err_code, (g < 6) ? 6 : 0);
      chk($sformatf("R3 closed gap %0d", g), bank_active, 0);
    end

    // R7: close to reopen; activate-to-activate is 6+g so R7 wins (R13)
    for (int g = 1; g <= 6; g++) begin
      do_reset();
      issue(P_ACT, 1'b1, 1'b0);
      idle(5);
      issue(P_PRE, 1'b1, 1'b0);
      idle(g - 1);
      issue(P_ACT, 1'b1, 1'b0);
      chk($sformatf("R7 gap %0d", g), err_code, (g < 3) ? 7 : 0);
    end

    // R4 and R8: auto-closing read at 3, then reopen after g
    for (int g = 1; g <= 8; g++) begin
      int e;
      do_reset();
      issue(P_ACT, 1'b0, 1'b0);
      idle(2);
      issue(P_RD, 1'b0, 1'b1);
      chk($sformatf("R4 autoclose %0d", g), bank_active, 0);
      idle(g - 1);
      issue(P_ACT, 1'b0, 1'b0);
      e = (g < 3) ? 7 : ((3 + g < 9) ? 8 : 0);
      chk($sformatf("R8 gap %0d", g), err_code, e);
    end

    // R9: cross-bank activates
    for (int g = 1; g <= 4; g++) begin
      do_reset();
      issue(P_ACT, 1'b0, 1'b0);
      idle(g - 1);
      issue(P_ACT, 1'b1, 1'b0);
      chk($sformatf("R9 gap %0d", g), err_code, (g < 2) ? 9 : 0);
      chk($sformatf("R2 both open %0d", g), bank_active, 3);
    end

    // R10: mode load then a command
    for (int g = 1; g <= 4; g++) begin
      do_reset();
      issue(P_MODE, 1'b0, 1'b0);
      idle(g - 1);
      issue(P_ACT, 1'b0, 1'b0);
      chk($sformatf("R10 gap %0d", g), err_code, (g < 2) ? 1 : 0);
    end

    // R2: precharge-all closes both banks
    do_reset();
    issue(P_ACT, 1'b0, 1'b0);
    idle(1);
    issue(P_ACT, 1'b1, 1'b0);
    idle(7);
    issue(P_PRE, 1'b0, 1'b1);
    chk("R2 close all banks", bank_active, 0);
    chk("R2 close all no error", err_flag, 0);

    // R3: single precharge leaves other bank open
    do_reset();
    issue(P_ACT, 1'b0, 1'b0);
    idle(1);
    issue(P_ACT, 1'b1, 1'b0);
    idle(7);
    issue(P_PRE, 1'b0, 1'b0);
    chk("R3 only bank0 closed", bank_active, 2);

    // R11: state errors
    do_reset();
    issue(P_ACT, 1'b0, 1'b0);
    idle(11);
    issue(P_ACT, 1'b0, 1'b0);
    chk("R11 reopen", err_code, 2);
    do_reset();
    issue(P_WR, 1'b1, 1'b0);
    chk("R11 idle access", err_code, 3);
    do_reset();
    issue(P_ACT, 1'b1, 1'b0);
    idle(11);
    issue(P_REF, 1'b0, 1'b0);
    chk("R11 refresh busy", err_code, 4);
    do_reset();
    idle(2);
    issue(P_REF, 1'b0, 1'b0);
    chk("R11 refresh idle ok", err_flag, 0);

    // R13: reopen of an open bank inside the activate window -> lowest code 2
    do_reset();
    issue(P_ACT, 1'b0, 1'b0);
    idle(3);
    issue(P_ACT, 1'b0, 1'b0);
    chk("R13 priority", err_code, 2);

    // R12: first code held after a later violation
    issue(P_RD, 1'b1, 1'b0);
    idle(3);
    chk("R12 sticky flag", err_flag, 1);
    chk("R12 first code kept", err_code, 2);

    finish_up();
  end

endmodule